// File: doc/BRIEF.md
# Two-Digit Modulo-7/Modulo-8 Counter with Seven-Segment Decode

This block is a two-digit counter. The low digit advances on every clock and runs through seven values, 0 to 6. The high digit advances once for each wrap of the low digit and runs through eight values, 0 to 7. The pair therefore repeats every 56 clocks.

Neither digit wraps by clearing itself. Each digit has a terminal-count detector, which is an AND of selected count bits. Its inverted output is an active-low load strobe. While the strobe is low and the digit is enabled, the next rising edge loads zero into the digit, so the terminal value stays visible for a full clock. The low digit's detector ANDs bits 1 and 2 (value 6). The high digit's detector ANDs bits 0, 1 and 2 (value 7).

Both counters share one clock. The high digit is enabled by the low digit's terminal-count signal. Each digit drives a decoder whose active-low segment outputs can drive a common-anode display directly.

Each digit uses a three-state action selector, evaluated every cycle:
- HOLD: not enabled, so the value is kept.
- STEP: enabled and not at terminal count, so the value goes up by one.
- LOAD: enabled and at terminal count, so zero is loaded.

The transitions are as follows. A digit goes to HOLD whenever its enable is low. It goes from STEP to LOAD when the terminal count is reached. It goes from LOAD to STEP once zero has been loaded. A synchronous reset overrides every action.

Top module: `modcount2_seg`

## Requirements
- R1: `lo_cnt` follows 0,1,2,3,4,5,6,0,... and advances by one on every rising edge outside reset. The value 6 is held for exactly one full clock before 0 appears.
- R2: `hi_cnt` changes only on an edge where `lo_cnt` was 6 before the edge, and then increases by one. On every other edge it keeps its value.
- R3: `hi_cnt` goes from 7 back to 0 on the edge where `lo_cnt` wraps from 6, so the pair repeats every 56 clocks and never shows a value above 7.
- R4: `lo_load_n` is 0 exactly while `lo_cnt` is 6, which is one clock in every seven. It is 1 otherwise.
- R5: `hi_load_n` is 0 exactly while `hi_cnt` is 7 and `lo_cnt` is 6, which is one clock in every 56. It is 1 otherwise.
- R6: When `rst` is 1 at a rising edge, both counts become 0 and both load strobes read 1 after that edge, whatever the earlier state. Counting resumes from 0 on the first edge with `rst` at 0.
- R7: The segment outputs are active low, with bit 0 for segment a and bit 6 for segment g. For digit values 0 to 9 they take the following values (hex): 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10. Codes 10 to 15 give 7F (all segments dark).
- R8: Segment a (bit 0) is dark (1) for digits 1 and 4 and lit (0) for 0, 2, 3, 5, 6 and 7, on both digit outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cnt | output | 4 | Low digit count, 0 to 6 |
| hi_cnt | output | 4 | High digit count, 0 to 7 |
| lo_load_n | output | 1 | Active-low load strobe of the low digit |
| hi_load_n | output | 1 | Active-low load strobe of the high digit |
| lo_seg_n | output | 7 | Low digit segments g..a, active low |
| hi_seg_n | output | 7 | High digit segments g..a, active low |

## Verification
The only input besides the clock is the reset. The properties assume that reset is held for at least one edge before any counting is judged, and they treat the cycle after a reset edge as a fresh start. The stimulus asserts reset from time zero for two edges. It then lets the counter run through more than two 56-count periods. It pulses reset once in the middle of a period, with both digits at nonzero values, and then runs a further full period. Every count value that can be reached, and both terminal-count coincidences, therefore occur while reset is low.

// File: rtl/modcount2_pkg.sv
package modcount2_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } digit_act_e;

    localparam seg_t SEG_DARK = '1;
endpackage

// File: rtl/mc_digit.sv
module mc_digit #(
    parameter int                W       = 4,
    parameter logic [W-1:0]      TC_MASK = 4'b0110
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         tc,
    output logic         load_n
);
    import modcount2_pkg::*;

    localparam logic [W-1:0] LOAD_VAL = '0;
    localparam logic [W-1:0] ONE      = W'(1);

    digit_act_e act;

    // terminal count: AND of the bits selected by the mask
    assign tc     = &(cnt | ~TC_MASK);
    assign load_n = ~(tc & en);

    always_comb begin
        if (!en)
            act = ACT_HOLD;
        else if (!load_n)
            act = ACT_LOAD;
        else
            act = ACT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= LOAD_VAL;
        end else begin
            unique case (act)
                ACT_HOLD: cnt <= cnt;
                ACT_STEP: cnt <= cnt + ONE;
                ACT_LOAD: cnt <= LOAD_VAL;
                default:  cnt <= LOAD_VAL;
            endcase
        end
    end
endmodule

// File: rtl/mc_seg7.sv
module mc_seg7 (
    input  modcount2_pkg::digit_t code,
    output modcount2_pkg::seg_t   seg_n
);
    import modcount2_pkg::*;

    always_comb begin
        unique case (code)
            4'd0:    seg_n = 7'h40;
            4'd1:    seg_n = 7'h79;
            4'd2:    seg_n = 7'h24;
            4'd3:    seg_n = 7'h30;
            4'd4:    seg_n = 7'h19;
            4'd5:    seg_n = 7'h12;
            4'd6:    seg_n = 7'h02;
            4'd7:    seg_n = 7'h78;
            4'd8:    seg_n = 7'h00;
            4'd9:    seg_n = 7'h10;
            default: seg_n = SEG_DARK;
        endcase
    end
endmodule

// File: rtl/modcount2_seg.sv
module modcount2_seg #(
    parameter logic [3:0] LO_TC_MASK = 4'b0110,
    parameter logic [3:0] HI_TC_MASK = 4'b0111
) (
    input  logic       clk,
    input  logic       rst,
    output logic [3:0] lo_cnt,
    output logic [3:0] hi_cnt,
    output logic       lo_load_n,
    output logic       hi_load_n,
    output logic [6:0] lo_seg_n,
    output logic [6:0] hi_seg_n
);
    import modcount2_pkg::*;

    logic lo_tc;
    logic hi_tc;

    mc_digit #(.W(DIGIT_W), .TC_MASK(LO_TC_MASK)) lo_dig_i (
        .clk    (clk),
        .rst    (rst),
        .en     (1'b1),
        .cnt    (lo_cnt),
        .tc     (lo_tc),
        .load_n (lo_load_n)
    );

    // high digit steps on the low digit's terminal cycle, same clock
    mc_digit #(.W(DIGIT_W), .TC_MASK(HI_TC_MASK)) hi_dig_i (
        .clk    (clk),
        .rst    (rst),
        .en     (lo_tc),
        .cnt    (hi_cnt),
        .tc     (hi_tc),
        .load_n (hi_load_n)
    );

    mc_seg7 lo_dec_i (.code(lo_cnt), .seg_n(lo_seg_n));
    mc_seg7 hi_dec_i (.code(hi_cnt), .seg_n(hi_seg_n));

    logic unused_hi_tc;
    assign unused_hi_tc = hi_tc;
endmodule

// File: rtl/modcount2_seg_chk.sv
module modcount2_seg_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] lo_cnt,
    input logic [3:0] hi_cnt,
    input logic       lo_load_n,
    input logic       hi_load_n,
    input logic [6:0] lo_seg_n,
    input logic [6:0] hi_seg_n
);
    a_r1_lo_step: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt < 4'd6) |=> (lo_cnt == 4'($past(lo_cnt) + 4'd1)));

    a_r1_lo_wrap: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt == 4'd6) |=> (lo_cnt == 4'd0));

    a_r2_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt != 4'd6) |=> $stable(hi_cnt));

    a_r2_hi_step: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt == 4'd6 && hi_cnt < 4'd7) |=> (hi_cnt == 4'($past(hi_cnt) + 4'd1)));

    a_r3_hi_wrap: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt == 4'd6 && hi_cnt == 4'd7) |=> (hi_cnt == 4'd0));

    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt <= 4'd6 && hi_cnt <= 4'd7));

    a_r4_lo_strobe: assert property (@(posedge clk) disable iff (rst)
        (lo_load_n == (lo_cnt != 4'd6)));

    a_r4_lo_pulse: assert property (@(posedge clk) disable iff (rst)
        !lo_load_n |=> lo_load_n);

    a_r5_hi_strobe: assert property (@(posedge clk) disable iff (rst)
        (hi_load_n == !(hi_cnt == 4'd7 && lo_cnt == 4'd6)));

    a_r6_reset: assert property (@(posedge clk)
        rst |=> (lo_cnt == 4'd0 && hi_cnt == 4'd0 && lo_load_n && hi_load_n));

    a_r8_lo_seg_a: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt == 4'd1 || lo_cnt == 4'd4) == lo_seg_n[0]);

    a_r8_hi_seg_a: assert property (@(posedge clk) disable iff (rst)
        (hi_cnt == 4'd1 || hi_cnt == 4'd4) == hi_seg_n[0]);
endmodule

bind modcount2_seg modcount2_seg_chk chk_i (.*);

// File: tb/modcount2_seg_tb_top.sv
module modcount2_seg_tb_top;
    logic       clk;
    logic       rst;
    logic [3:0] lo_cnt;
    logic [3:0] hi_cnt;
    logic       lo_load_n;
    logic       hi_load_n;
    logic [6:0] lo_seg_n;
    logic [6:0] hi_seg_n;

    int checks;
    int fails;
    bit done;

    typedef struct {
        logic [3:0] lo;
        logic [3:0] hi;
        logic       lo_ld;
        logic       hi_ld;
        bit         in_rst;
        bit         hi_wrap;
    } exp_t;

    exp_t       q[$];
    logic [3:0] ref_lo;
    logic [3:0] ref_hi;

    modcount2_seg dut_i (
        .clk       (clk),
        .rst       (rst),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .lo_load_n (lo_load_n),
        .hi_load_n (hi_load_n),
        .lo_seg_n  (lo_seg_n),
        .hi_seg_n  (hi_seg_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // R7 segment table, active low, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        case (d)
            4'd0: return 7'h40;
            4'd1: return 7'h79;
            4'd2: return 7'h24;
            4'd3: return 7'h30;
            4'd4: return 7'h19;
            4'd5: return 7'h12;
            4'd6: return 7'h02;
            4'd7: return 7'h78;
            4'd8: return 7'h00;
            4'd9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected result after the next edge
    task automatic drive(input bit r);
        exp_t e;
        rst = r;
        e.in_rst  = r;
        e.hi_wrap = 1'b0;
        if (r) begin
            ref_lo = 4'd0;
            ref_hi = 4'd0;
        end else if (ref_lo == 4'd6) begin
            ref_lo = 4'd0;
            e.hi_wrap = (ref_hi == 4'd7);
            ref_hi = (ref_hi == 4'd7) ? 4'd0 : ref_hi + 4'd1;
        end else begin
            ref_lo = ref_lo + 4'd1;
        end
        e.lo    = ref_lo;
        e.hi    = ref_hi;
        e.lo_ld = !(ref_lo == 4'd6);
        e.hi_ld = !(ref_lo == 4'd6 && ref_hi == 4'd7);
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare 2 ns after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (e.in_rst) begin
                check(lo_cnt == 4'd0 && hi_cnt == 4'd0, "R6 counts", {hi_cnt, lo_cnt}, 0);
                check(lo_load_n && hi_load_n, "R6 strobes", {hi_load_n, lo_load_n}, 3);
            end else begin
                check(lo_cnt == e.lo, "R1", lo_cnt, e.lo);
                check(hi_cnt == e.hi, e.hi_wrap ? "R3" : "R2", hi_cnt, e.hi);
                check(lo_load_n == e.lo_ld, "R4", lo_load_n, e.lo_ld);
                check(hi_load_n == e.hi_ld, "R5", hi_load_n, e.hi_ld);
            end
            check(lo_seg_n == seg_of(e.lo), "R7 lo", lo_seg_n, seg_of(e.lo));
            check(hi_seg_n == seg_of(e.hi), "R7 hi", hi_seg_n, seg_of(e.hi));
            check(lo_seg_n[0] == (e.lo == 4'd1 || e.lo == 4'd4), "R8 lo", lo_seg_n[0],
                  (e.lo == 4'd1 || e.lo == 4'd4));
            check(hi_seg_n[0] == (e.hi == 4'd1 || e.hi == 4'd4), "R8 hi", hi_seg_n[0],
                  (e.hi == 4'd1 || e.hi == 4'd4));
        end
    end

    initial begin
        ref_lo = 4'd0;
        ref_hi = 4'd0;
        drive(1'b1);
        drive(1'b1);
        for (int i = 0; i < 120; i++) drive(1'b0);   // two full periods plus
        drive(1'b1);                                  // R6 mid-count reset
        for (int i = 0; i < 60; i++) drive(1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule